// File: doc/BRIEF.md
# Memory Fill Write Master

This block is a bus master that only writes. It fills a memory region with a known number pattern over a 64-bit shared processor bus, where a central arbiter grants access. A small control port supplies a start address, a transfer count and a one-cycle start pulse. For each transfer the engine requests the bus, presents the address and a data word, and waits for two acknowledges: first the address, then the write data. It then steps to the next doubleword.

Each data word holds the running transfer index in its upper half and the bitwise inverse of that index in its lower half. A memory dump of the filled region can therefore be checked by eye. Every bus qualifier other than request, address and data is tied to a fixed value. A master-error input aborts the run and sets a sticky error flag.

Top module: `wfill_master`

## Requirements
- R1: After reset the engine is idle: `bus_req`, `busy`, `done` and `err` are all 0.
- R2: The fixed qualifiers never change. `bus_rnw`=0, `bus_be`=8'hFF, `bus_prio`=2'b11, `bus_size`=4'b0000, `bus_type`=3'b000 (memory transfer), and `bus_lock`, `bus_abort`, `bus_compress`, `bus_guarded` and `bus_ordered` are all 0.
- R3: A `cfg_start` pulse while idle, with a nonzero `cfg_xfer_cnt`, raises `busy` and `bus_req` in the next cycle. In that cycle `bus_addr` equals `cfg_base_addr`.
- R4: `bus_req` stays at 1 until a cycle in which `bus_addr_ack` is 1. It is 0 in the cycle after that acknowledge.
- R5: `bus_addr` and `bus_wdata` stay stable from the request until `bus_wr_ack`. After the write acknowledge, the address of the next transfer is the previous address plus 8.
- R6: For transfer index i, counted from 0, `bus_wdata[63:32]` = i and `bus_wdata[31:0]` = ~i.
- R7: After the write acknowledge of the last programmed transfer, in the next cycle `done`=1, `busy`=0 and `bus_req`=0.
- R8: A start with `cfg_xfer_cnt`=0 makes no request and sets `done` in the next cycle.
- R9: `bus_err` seen while busy stops the run. In the next cycle `err`=1, `busy`=0, `bus_req`=0 and `done`=0. This holds even when an acknowledge arrives in the same cycle. `err` then stays at 1 while idle.
- R10: A `cfg_start` pulse while busy is ignored. The address, the data sequence and the transfer count continue unchanged.
- R11: A new accepted start clears both `done` and `err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base_addr | input | AW | First address of the fill |
| cfg_xfer_cnt | input | CW | Number of 64-bit transfers |
| cfg_start | input | 1 | One-cycle start pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | 2*CW | Write data: index over inverted index |
| bus_be | output | 2*CW/8 | Byte enables, all ones |
| bus_rnw | output | 1 | Read/not-write, held 0 |
| bus_prio | output | 2 | Request priority, held 2'b11 |
| bus_size | output | 4 | Transfer size code, held 0 |
| bus_type | output | 3 | Transfer type code, held 0 (memory) |
| bus_lock | output | 1 | Bus lock, held 0 |
| bus_abort | output | 1 | Abort, held 0 |
| bus_compress | output | 1 | Compressed qualifier, held 0 |
| bus_guarded | output | 1 | Guarded qualifier, held 0 |
| bus_ordered | output | 1 | Ordered qualifier, held 0 |
| bus_addr_ack | input | 1 | Address acknowledge from the bus |
| bus_wr_ack | input | 1 | Write-data acknowledge from the bus |
| bus_err | input | 1 | Master error from the bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky: last run completed |
| err | output | 1 | Sticky: last run aborted by error |

## Verification
Two events can land on the same clock edge: the error abort and an acknowledge, either the address acknowledge or the write-data acknowledge. The bench picks random runs and, at a random transfer, raises `bus_err` together with one of the two acknowledges. It then expects the next cycle to show an idle engine with `err` set and `done` clear, not an advanced transfer. Random acknowledge delays and a start pulse sent in the middle of a run complete the stimulus. Every address and data word is compared against the index-derived pattern.

// File: rtl/wfill_master.sv
module wfill_master #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_base_addr,
  input  logic [CW-1:0]     cfg_xfer_cnt,
  input  logic              cfg_start,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic [2*CW-1:0]   bus_wdata,
  output logic [2*CW/8-1:0] bus_be,
  output logic              bus_rnw,
  output logic [1:0]        bus_prio,
  output logic [3:0]        bus_size,
  output logic [2:0]        bus_type,
  output logic              bus_lock,
  output logic              bus_abort,
  output logic              bus_compress,
  output logic              bus_guarded,
  output logic              bus_ordered,
  input  logic              bus_addr_ack,
  input  logic              bus_wr_ack,
  input  logic              bus_err,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int DW   = 2 * CW;
  localparam int NBE  = DW / 8;
  localparam int STEP = NBE;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q, tot_q;
  logic          done_q, err_q;
  logic          last;

  assign last = (cnt_q + CW'(1)) == tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cfg_start) begin
          addr_q <= cfg_base_addr;
          cnt_q  <= '0;
          tot_q  <= cfg_xfer_cnt;
          err_q  <= 1'b0;
          done_q <= (cfg_xfer_cnt == '0);
          if (cfg_xfer_cnt != '0) st <= S_ADDR;
        end
        S_ADDR: if (bus_err) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else if (bus_addr_ack) begin
          st <= S_DATA;
        end
        S_DATA: if (bus_err) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else if (bus_wr_ack) begin
          addr_q <= addr_q + AW'(STEP);
          cnt_q  <= cnt_q + CW'(1);
          if (last) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req      = (st == S_ADDR);
  assign bus_addr     = addr_q;
  assign bus_wdata    = {cnt_q, ~cnt_q};
  assign bus_be       = {NBE{1'b1}};
  assign bus_rnw      = 1'b0;
  assign bus_prio     = 2'b11;
  assign bus_size     = 4'b0000;
  assign bus_type     = 3'b000;
  assign bus_lock     = 1'b0;
  assign bus_abort    = 1'b0;
  assign bus_compress = 1'b0;
  assign bus_guarded  = 1'b0;
  assign bus_ordered  = 1'b0;
  assign busy         = (st != S_IDLE);
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/wfill_master_chk.sv
module wfill_master_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_start,
  input logic            bus_req,
  input logic [AW-1:0]   bus_addr,
  input logic [2*CW-1:0] bus_wdata,
  input logic            bus_addr_ack,
  input logic            bus_wr_ack,
  input logic            bus_err,
  input logic            busy,
  input logic            done,
  input logic            err
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_addr_ack && !bus_err |=> bus_req);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addr_ack |=> !bus_req);

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_wr_ack && !bus_err |=> $stable(bus_addr) && $stable(bus_wdata));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_err |=> !busy && err && !done);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !cfg_start |=> err);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_req);
endmodule

bind wfill_master wfill_master_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .bus_req(bus_req),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_addr_ack(bus_addr_ack),
  .bus_wr_ack(bus_wr_ack), .bus_err(bus_err), .busy(busy), .done(done), .err(err)
);

// File: tb/wfill_master_tb_top.sv
`timescale 1ns/1ps
module wfill_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base_addr = '0;
  logic [31:0] cfg_xfer_cnt = '0;
  logic        cfg_start = 1'b0;
  logic        bus_addr_ack = 1'b0, bus_wr_ack = 1'b0, bus_err = 1'b0;
  logic        bus_req, bus_rnw, bus_lock, bus_abort, bus_compress, bus_guarded, bus_ordered;
  logic [31:0] bus_addr;
  logic [63:0] bus_wdata;
  logic [7:0]  bus_be;
  logic [1:0]  bus_prio;
  logic [3:0]  bus_size;
  logic [2:0]  bus_type;
  logic        busy, done, err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wfill_master dut_i (.*);

  function automatic logic [63:0] exp_word(input int unsigned i);
    logic [31:0] c = i[31:0];
    return {c, ~c};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_const();
    chk({bus_rnw, bus_be, bus_prio, bus_size, bus_type, bus_lock, bus_abort,
         bus_compress, bus_guarded, bus_ordered} == {1'b0, 8'hFF, 2'b11, 4'h0, 3'h0, 5'b0},
        "R2", {bus_rnw, bus_be, bus_prio, bus_size, bus_type}, {1'b0, 8'hFF, 2'b11, 7'h0});
  endtask

  task automatic chk_err_stop();
    chk(err && !busy && !bus_req && !done, "R9", {err, busy, bus_req, done}, 4'b1000);
    repeat (3) @(negedge clk);
    chk(err && !busy, "R9", {err, busy}, 2'b10);
  endtask

  // emode: 0 none, 1 error with address ack, 2 error with write ack
  task automatic run_job(input logic [31:0] base, input int n, input int emode,
                         input int ek, input bit poke);
    @(negedge clk);
    cfg_base_addr = base; cfg_xfer_cnt = n; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(!err, "R11", err, 0);
    if (n == 0) begin
      chk(done && !busy && !bus_req, "R8", {done, busy, bus_req}, 3'b100);
      return;
    end
    chk(!done && busy, "R11", {done, busy}, 2'b01);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ea = base + 32'(8 * i);
      chk(bus_req, "R3", bus_req, 1);
      chk(bus_addr == ea, "R5", bus_addr, ea);
      chk(bus_wdata == exp_word(i), "R6", bus_wdata, exp_word(i));
      chk_const();
      if (poke && i == 1) begin
        cfg_base_addr = ~base; cfg_xfer_cnt = 99; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(bus_req && bus_addr == ea && bus_wdata == exp_word(i), "R10", bus_addr, ea);
      end
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(bus_req && bus_addr == ea, "R4", {bus_req, bus_addr}, {1'b1, ea});
      end
      bus_addr_ack = 1'b1;
      if (emode == 1 && i == ek) bus_err = 1'b1;
      @(negedge clk);
      bus_addr_ack = 1'b0; bus_err = 1'b0;
      if (emode == 1 && i == ek) begin chk_err_stop(); return; end
      chk(!bus_req && busy, "R4", {bus_req, busy}, 2'b01);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(!bus_req && bus_addr == ea && bus_wdata == exp_word(i), "R5", bus_wdata, exp_word(i));
      end
      bus_wr_ack = 1'b1;
      if (emode == 2 && i == ek) bus_err = 1'b1;
      @(negedge clk);
      bus_wr_ack = 1'b0; bus_err = 1'b0;
      if (emode == 2 && i == ek) begin chk_err_stop(); return; end
    end
    chk(done && !busy && !bus_req, "R7", {done, busy, bus_req}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!bus_req && !busy && !done && !err, "R1", {bus_req, busy, done, err}, 0);
    chk_const();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !busy && !done && !err, "R1", {bus_req, busy, done, err}, 0);
    run_job(32'h0000_1000, 3, 0, 0, 1'b0);
    run_job(32'h0000_2000, 0, 0, 0, 1'b0);
    run_job(32'hFFFF_FFF0, 4, 0, 0, 1'b1);
    run_job(32'h0000_3000, 5, 1, 2, 1'b0);
    run_job(32'h0000_4000, 3, 0, 0, 1'b0);
    run_job(32'h0000_5000, 4, 2, 3, 1'b0);
    run_job(32'h0000_6000, 2, 1, 0, 1'b0);
    for (int j = 0; j < 20; j++) begin
      int n  = $urandom_range(0, 6);
      int em = $urandom_range(0, 2);
      int ek = (n > 0) ? $urandom_range(0, n - 1) : 0;
      logic [31:0] b = {$urandom_range(0, 32'h0FFF_FFFF), 3'b000};
      run_job(b, n, em, ek, (n > 2) && ($urandom_range(0, 1) == 1));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule